// File: doc/BRIEF.md
# Serial Transmit Path with Holding Queue

This block is the transmit half of an asynchronous serial port. A host pushes bytes through a one-cycle write strobe. With queueing enabled the bytes wait in a 128-entry first-in first-out store. With queueing disabled a single holding slot takes the byte instead. A shifter takes one byte at a time and drives the serial line. It sends a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit is held for 16 or 8 pulses of an oversampling enable input.

The block reports two flags. One says that no byte is waiting for the shifter. The other says that the line has gone quiet. It also raises an interrupt request when the queue drains below a selectable threshold, and again when the queue runs dry. A write that finds no room is discarded, and a sticky overflow flag records the loss.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` and `shift_empty` are 1, and `irq` and `ovf` are 0.
- R2: A character is a 0 start bit, then `cfg_wlen`+5 data bits with bit 0 first, then the parity bit when `cfg_par_en` is 1, then one stop bit of 1, or two when `cfg_stop2` is 1.
- R3: `cfg_par_mode` chooses the parity bit: 0 makes the count of ones over data and parity odd, 1 makes it even, 2 sends a constant 1 and 3 sends a constant 0. Only the configured data bits count.
- R4: Every bit, the start bit included, lasts exactly 16 `tick` pulses when `cfg_os8` is 0 and exactly 8 when it is 1.
- R5: With `cfg_fifo_en` at 1, up to 128 bytes wait in the queue and go out in write order. A write that finds the queue full is dropped and sets `ovf`. `ovf` stays set until `ovf_clr` is pulsed.
- R6: With `cfg_fifo_en` at 0, only one byte can wait. A write made while that byte still waits is dropped and sets `ovf`.
- R7: `hold_empty` is 1 exactly when no byte waits for the shifter. In non-queued mode it rises when the held byte moves into the shifter. It falls only as a result of a write.
- R8: `shift_empty` is 1 only while no character is being sent, and in queued mode only when the queue is also empty. While it is 1, `txd` is 1.
- R9: A character starts on a `tick` pulse when the shifter is idle and a byte is waiting. When the queue still holds bytes, the next start bit follows the last stop bit with no gap.
- R10: With `cfg_irq_en` at 1, `irq` rises when a transfer into the shifter takes the queue level from at or above the threshold to below it. The threshold is 8, 16, 32 or 56 for `cfg_trig` 0 to 3. `irq` rises again when a transfer empties the queue.
- R11: `irq` clears on the edge after a write or an `ack` pulse, and stays 0 while `cfg_irq_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling clock enable |
| cfg_fifo_en | input | 1 | 1 selects the 128-entry queue, 0 selects a single holding slot |
| cfg_os8 | input | 1 | 1 makes each bit 8 ticks long, 0 makes it 16 ticks long |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Adds a parity bit |
| cfg_par_mode | input | 2 | Parity: 0 odd, 1 even, 2 constant 1, 3 constant 0 |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_trig | input | 2 | Interrupt threshold: 8, 16, 32 or 56 |
| cfg_irq_en | input | 1 | Enables the interrupt request |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to send |
| ack | input | 1 | Status acknowledge that clears the interrupt |
| ovf_clr | input | 1 | Clears the overflow flag |
| txd | output | 1 | Serial line, high when idle |
| hold_empty | output | 1 | No byte waits for the shifter |
| shift_empty | output | 1 | Shifter idle, and in queued mode the queue is empty |
| irq | output | 1 | Transmit-empty interrupt request |
| ovf | output | 1 | Sticky flag for a dropped write |

## Verification
The hardest states to reach are the full queue and the threshold crossing. Neither shows up while the host writes slowly, because the shifter drains a byte at every frame boundary. To get there, the bench writes a burst of 131 bytes on consecutive cycles. That is faster than a single frame lasts, so exactly one byte leaves for the shifter and the queue fills at the 129th write. The last two writes overflow, and the frames that follow show whether they really start back to back. For each of the four thresholds, a burst of threshold plus two bytes makes the crossing land on the third transfer into the shifter. The bench can predict that instant from the count of frames it has already decoded.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W   = 8;
    localparam int MIN_WORD = 5;
    localparam int FRAME_W  = 1 + DATA_W + 1 + 2;
    localparam int OS_FAST  = 8;
    localparam int OS_SLOW  = 16;
    localparam int TCNT_W   = $clog2(OS_SLOW);
    localparam int NB_W     = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        PAR_ODD   = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_MARK  = 2'd2,
        PAR_SPACE = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        par_mode_e  par_mode;
        logic       stop2;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [NB_W-1:0]    nbits;
    } frame_t;

    function automatic logic [TCNT_W-1:0] last_tick(input logic os8);
        return os8 ? TCNT_W'(OS_FAST - 1) : TCNT_W'(OS_SLOW - 1);
    endfunction

    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 32;
            default: return 56;
        endcase
    endfunction

    // Lays the whole character out LSB-first, with the line level of each bit
    function automatic frame_t build_frame(input logic [DATA_W-1:0] d, input fmt_t f);
        frame_t             fr;
        logic [DATA_W-1:0]  m;
        logic               par;
        int unsigned        nd;
        nd = MIN_WORD + int'(f.wlen);
        m  = d & DATA_W'((1 << nd) - 1);
        case (f.par_mode)
            PAR_ODD:  par = ~(^m);
            PAR_EVEN: par = ^m;
            PAR_MARK: par = 1'b1;
            default:  par = 1'b0;
        endcase
        fr.bits    = '1;
        fr.bits[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(nd)) fr.bits[1+i] = m[i];
        end
        if (f.par_en) fr.bits[1+nd] = par;
        fr.nbits = NB_W'(2 + nd + (f.par_en ? 1 : 0) + (f.stop2 ? 1 : 0));
        return fr;
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic          pop,
    input  logic          cap_one,
    input  logic          ovf_clr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt,
    output logic          full,
    output logic          ovf
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          push_ok;

    assign full      = cap_one ? (count != '0) : (count == CW'(DEPTH));
    assign push_ok   = push_req && !full;
    assign count_nxt = count + CW'(push_ok) - CW'(pop);
    assign dout      = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop)     rptr <= bump(rptr);
            count <= count_nxt;
            if (push_req && full) ovf <= 1'b1;
            else if (ovf_clr)     ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              os8,
    input  fmt_t              fmt,
    input  logic              avail,
    input  logic [DATA_W-1:0] din,
    output logic              pop,
    output logic              txd,
    output logic              busy
);

    logic [TCNT_W-1:0]  tcnt;
    logic [FRAME_W-1:0] shreg;
    logic [NB_W-1:0]    rem;
    logic               bit_end, frame_end;
    frame_t             nxt;

    assign bit_end   = busy && tick && (tcnt == last_tick(os8));
    assign frame_end = bit_end && (rem == NB_W'(1));
    assign pop       = tick && avail && (!busy || frame_end);
    assign nxt       = build_frame(din, fmt);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            txd   <= 1'b1;
            tcnt  <= '0;
            rem   <= '0;
            shreg <= '1;
        end else if (pop) begin
            busy  <= 1'b1;
            shreg <= nxt.bits;
            rem   <= nxt.nbits;
            txd   <= nxt.bits[0];
            tcnt  <= '0;
        end else if (frame_end) begin
            busy <= 1'b0;
            txd  <= 1'b1;
            tcnt <= '0;
        end else if (bit_end) begin
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            txd   <= shreg[1];
            rem   <= rem - NB_W'(1);
            tcnt  <= '0;
        end else if (busy && tick) begin
            tcnt <= tcnt + TCNT_W'(1);
        end
    end

endmodule

// File: rtl/sertx_irq.sv
module sertx_irq
    import sertx_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          irq_en,
    input  logic          fifo_en,
    input  logic [1:0]    trig,
    input  logic          pop,
    input  logic          wr,
    input  logic          ack,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] count_nxt,
    output logic          irq
);

    logic [CW-1:0] lvl;
    logic          drop_below, went_empty, fire;

    assign lvl        = CW'(trig_level(trig));
    assign drop_below = fifo_en && (count >= lvl) && (count_nxt < lvl);
    assign went_empty = count_nxt == '0;
    assign fire       = pop && (drop_below || went_empty);

    always_ff @(posedge clk) begin
        if (rst || !irq_en) irq <= 1'b0;
        else if (wr)        irq <= 1'b0;
        else if (fire)      irq <= 1'b1;
        else if (ack)       irq <= 1'b0;
    end

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cfg_fifo_en,
    input  logic       cfg_os8,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_mode,
    input  logic       cfg_stop2,
    input  logic [1:0] cfg_trig,
    input  logic       cfg_irq_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       ack,
    input  logic       ovf_clr,
    output logic       txd,
    output logic       hold_empty,
    output logic       shift_empty,
    output logic       irq,
    output logic       ovf
);

    fmt_t              fmt;
    logic [DATA_W-1:0] q_dout;
    logic [CW-1:0]     count, count_nxt;
    logic              fifo_full, pop, busy;

    assign fmt.wlen     = cfg_wlen;
    assign fmt.par_en   = cfg_par_en;
    assign fmt.par_mode = par_mode_e'(cfg_par_mode);
    assign fmt.stop2    = cfg_stop2;

    sertx_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_req  (wr_en),
        .pop       (pop),
        .cap_one   (!cfg_fifo_en),
        .ovf_clr   (ovf_clr),
        .din       (wr_data),
        .dout      (q_dout),
        .count     (count),
        .count_nxt (count_nxt),
        .full      (fifo_full),
        .ovf       (ovf)
    );

    sertx_shifter u_shift (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .os8   (cfg_os8),
        .fmt   (fmt),
        .avail (count != '0),
        .din   (q_dout),
        .pop   (pop),
        .txd   (txd),
        .busy  (busy)
    );

    sertx_irq #(.CW(CW)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .irq_en    (cfg_irq_en),
        .fifo_en   (cfg_fifo_en),
        .trig      (cfg_trig),
        .pop       (pop),
        .wr        (wr_en),
        .ack       (ack),
        .count     (count),
        .count_nxt (count_nxt),
        .irq       (irq)
    );

    assign hold_empty  = (count == '0);
    assign shift_empty = !busy && (!cfg_fifo_en || count == '0);

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic cfg_irq_en,
    input logic fifo_full,
    input logic txd,
    input logic hold_empty,
    input logic shift_empty,
    input logic irq,
    input logic ovf
);

    assert_quiet_line_R8: assert property (@(posedge clk) disable iff (rst)
        shift_empty |-> txd);

    assert_write_clears_irq_R11: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !irq);

    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
        !cfg_irq_en |=> !irq);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fifo_full) |=> ovf);

    assert_ovf_from_write_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(wr_en));

    assert_hold_fills_on_write_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_empty) |-> $past(wr_en));

endmodule

bind sertx_top sertx_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .cfg_irq_en  (cfg_irq_en),
    .fifo_full   (fifo_full),
    .txd         (txd),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty),
    .irq         (irq),
    .ovf         (ovf)
);

// File: tb/tb_sertx_top.sv
module tb_sertx_top;

    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 2;

    logic       clk = 1'b0, rst = 1'b1, tick = 1'b0;
    logic       cfg_fifo_en = 1'b1, cfg_os8 = 1'b0, cfg_par_en = 1'b0, cfg_stop2 = 1'b0, cfg_irq_en = 1'b0;
    logic [1:0] cfg_wlen = 2'd3, cfg_par_mode = 2'd0, cfg_trig = 2'd0;
    logic       wr_en = 1'b0, ack = 1'b0, ovf_clr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, hold_empty, shift_empty, irq, ovf;

    sertx_top dut (
        .clk(clk), .rst(rst), .tick(tick),
        .cfg_fifo_en(cfg_fifo_en), .cfg_os8(cfg_os8), .cfg_wlen(cfg_wlen),
        .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode), .cfg_stop2(cfg_stop2),
        .cfg_trig(cfg_trig), .cfg_irq_en(cfg_irq_en),
        .wr_en(wr_en), .wr_data(wr_data), .ack(ack), .ovf_clr(ovf_clr),
        .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty), .irq(irq), .ovf(ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) tick <= (cyc % TDIV) == 0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected line levels of one character, LSB-first
    logic [11:0] exp_bits[$];
    int          exp_n[$];
    int          pushed = 0;

    function automatic logic [11:0] model_bits(input logic [7:0] d, output int n);
        logic [11:0] b;
        int   nd, ones;
        logic p;
        nd   = 5 + int'(cfg_wlen);
        b    = 12'hFFF;
        b[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < nd; i++) begin
            b[1+i] = d[i];
            if (d[i]) ones++;
        end
        case (cfg_par_mode)
            2'd0:    p = (ones % 2) == 0;
            2'd1:    p = (ones % 2) == 1;
            2'd2:    p = 1'b1;
            default: p = 1'b0;
        endcase
        n = 1 + nd;
        if (cfg_par_en) begin b[n] = p; n++; end
        n = n + (cfg_stop2 ? 2 : 1);
        return b;
    endfunction

    task automatic push_exp(input logic [7:0] d);
        int n;
        logic [11:0] b;
        b = model_bits(d, n);
        exp_bits.push_back(b);
        exp_n.push_back(n);
        pushed++;
    endtask

    // Line monitor: decodes each character at mid-bit
    int done_cnt = 0;
    bit b2b_on = 0, b2b_first = 1;
    int unsigned prev_fall = 0;
    int prev_len = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (!rst && txd === 1'b0) begin : one_frame
                int bt, n, first_hi;
                int unsigned fall;
                logic [11:0] eb, got, mask;
                fall = cyc;
                bt   = (cfg_os8 ? 8 : 16) * TDIV;
                if (exp_n.size() == 0) begin
                    check(0, "R5", "unexpected character on line", 0, 1);
                    while (txd !== 1'b1 || !shift_empty) @(negedge clk);
                end else begin
                    eb = exp_bits.pop_front();
                    n  = exp_n.pop_front();
                    got = 12'hFFF;
                    first_hi = -1;
                    for (int c = 0; c <= (n - 1) * bt + bt / 2; c++) begin
                        if (c > 0) @(negedge clk);
                        if (first_hi < 0 && txd === 1'b1) first_hi = c;
                        if (c % bt == bt / 2) got[c / bt] = txd;
                    end
                    mask = 12'((1 << n) - 1);
                    check(((got ^ eb) & mask) == 0, "R2 R3", "character bits", got & mask, eb & mask);
                    if (eb[1]) check(first_hi == bt, "R4", "start bit length in clocks", first_hi, bt);
                    if (b2b_on && !b2b_first)
                        check(int'(fall - prev_fall) == prev_len, "R9", "start-to-start spacing",
                              fall - prev_fall, prev_len);
                    b2b_first = 0;
                    prev_fall = fall;
                    prev_len  = n * bt;
                    done_cnt++;
                end
            end
        end
    end

    task automatic send(input logic [7:0] d, input bit accepted);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        if (accepted) push_exp(d);
    endtask

    task automatic end_wr();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done();
        while (done_cnt != pushed) @(negedge clk);
        while (!(shift_empty && hold_empty)) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic set_fmt(input logic os8, input logic [1:0] wl, input logic pe,
                           input logic [1:0] pm, input logic st2);
        cfg_os8 = os8; cfg_wlen = wl; cfg_par_en = pe; cfg_par_mode = pm; cfg_stop2 = st2;
    endtask

    initial begin
        int base, lvl;
        void'($urandom(32'h5EED_0017));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(txd === 1'b1, "R1", "txd after reset", txd, 1);
        check(hold_empty === 1'b1, "R1", "hold_empty after reset", hold_empty, 1);
        check(shift_empty === 1'b1, "R1", "shift_empty after reset", shift_empty, 1);
        check(irq === 1'b0, "R1", "irq after reset", irq, 0);
        check(ovf === 1'b0, "R1", "ovf after reset", ovf, 0);

        // Directed characters: word length, stop count, each parity choice, both bit rates
        set_fmt(1'b0, 2'd3, 1'b0, 2'd0, 1'b0); send(8'hA5, 1); end_wr(); wait_done();
        set_fmt(1'b0, 2'd0, 1'b1, 2'd1, 1'b1); send(8'hF3, 1); end_wr(); wait_done();
        for (int pm = 0; pm < 4; pm++) begin
            set_fmt(1'b1, 2'd2, 1'b1, 2'(pm), 1'b0);
            send(8'h4B, 1); send(8'h0E, 1); end_wr(); wait_done();
        end
        check(shift_empty && hold_empty && txd, "R8", "line quiet after drain", {txd, shift_empty}, 3);

        // Random formats and data in queued mode
        for (int b = 0; b < 20; b++) begin
            int n;
            set_fmt(1'($urandom % 2), 2'($urandom % 4), 1'($urandom % 2), 2'($urandom % 4), 1'($urandom % 2));
            n = 1 + int'($urandom % 6);
            for (int i = 0; i < n; i++) send(8'($urandom), 1);
            end_wr();
            wait_done();
            check(txd === 1'b1 && shift_empty, "R8", "idle after batch", txd, 1);
            check(irq === 1'b0, "R11", "irq stays low when disabled", irq, 0);
        end

        // Full queue, overflow and back-to-back characters
        set_fmt(1'b1, 2'd3, 1'b0, 2'd0, 1'b0);
        b2b_on = 1; b2b_first = 1;
        for (int i = 0; i < 131; i++) begin
            @(negedge clk);
            if (i == 129) check(ovf === 1'b0, "R5", "no overflow while room remains", ovf, 0);
            wr_en = 1'b1;
            wr_data = 8'(i) ^ 8'h3C;
            if (i < 129) push_exp(wr_data);
        end
        end_wr();
        check(ovf === 1'b1, "R5", "write into full queue sets ovf", ovf, 1);
        check(hold_empty === 1'b0, "R7", "hold_empty low with bytes queued", hold_empty, 0);
        check(shift_empty === 1'b0, "R8", "shift_empty low while sending", shift_empty, 0);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        check(ovf === 1'b0, "R5", "ovf_clr clears ovf", ovf, 0);
        wait_done();
        b2b_on = 0;

        // Single holding slot
        cfg_fifo_en = 1'b0;
        set_fmt(1'b0, 2'd3, 1'b1, 2'd0, 1'b0);
        send(8'h81, 1); end_wr();
        for (int k = 0; k < 100 && !hold_empty; k++) @(negedge clk);
        check(hold_empty === 1'b1, "R7", "hold_empty once byte moved to shifter", hold_empty, 1);
        check(shift_empty === 1'b0, "R8", "shifter busy in non-queued mode", shift_empty, 0);
        send(8'h5A, 1); send(8'hC3, 0); end_wr();
        check(ovf === 1'b1, "R6", "second write into holding slot dropped", ovf, 1);
        check(hold_empty === 1'b0, "R7", "holding slot occupied", hold_empty, 0);
        wait_done();
        check(done_cnt == pushed, "R6", "only accepted bytes sent", done_cnt, pushed);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        check(ovf === 1'b0, "R5", "ovf cleared", ovf, 0);
        cfg_fifo_en = 1'b1;

        // Interrupt on threshold crossing and on empty queue
        for (int t = 0; t < 4; t++) begin
            set_fmt(1'b1, 2'd3, 1'b0, 2'd0, 1'b0);
            cfg_irq_en = 1'b1;
            cfg_trig = 2'(t);
            lvl = (t == 0) ? 8 : (t == 1) ? 16 : (t == 2) ? 32 : 56;
            base = done_cnt;
            for (int i = 0; i < lvl + 2; i++) send(8'($urandom), 1);
            end_wr();
            check(irq === 1'b0, "R11", "write leaves irq low", irq, 0);
            for (int k = 0; k < 20000 && !irq; k++) @(negedge clk);
            check(irq === 1'b1, "R10", "threshold interrupt raised", irq, 1);
            check(done_cnt - base == 2, "R10", "characters done before threshold", done_cnt - base, 2);
            check(hold_empty === 1'b0, "R10", "queue not yet empty at threshold", hold_empty, 0);
            pulse_ack();
            check(irq === 1'b0, "R11", "ack clears irq", irq, 0);
            for (int k = 0; k < 20000 && !irq; k++) @(negedge clk);
            check(irq === 1'b1 && hold_empty === 1'b1, "R10", "empty interrupt raised",
                  {irq, hold_empty}, 3);
            check(shift_empty === 1'b0, "R8", "last character still on line", shift_empty, 0);
            pulse_ack();
            wait_done();
        end
        cfg_irq_en = 1'b0;
        @(negedge clk);
        check(irq === 1'b0, "R11", "irq low after disable", irq, 0);
        check(exp_n.size() == 0, "R9", "all characters observed", exp_n.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule